// File: doc/BRIEF.md
# Byte-Lane Parity Checker with Size Masking

This block watches a 36-bit data bus made of four 9-bit lanes. Each lane carries eight data bits in its low positions and one parity bit in its top position. Every lane has its own parity tree. A single odd/even select sets the parity sense. The block drives an active-low error flag whenever at least one lane that takes part in the check has bad parity. The flag is advisory, and the surrounding system may choose to ignore it.

One instance sits on each port. The wide-port variant (`NARROW = 0`) always checks all four lanes. The narrow-port variant (`NARROW = 1`) uses the current bus size and the lane position to decide which lanes take part. Lanes that carry no valid data in the current transfer cannot pull the flag low. The flag is purely combinational from the bus and the select inputs. It stays high whenever the port is not enabled for input.

Top module: `lane_parity_check`

## Requirements
- R1: Lane k (k = 0..3) occupies bus bits 9k..9k+8. Bits 9k..9k+7 are its data and bit 9k+8 is its parity bit.
- R2: With `odd_sel` = 1, a lane passes when the XOR of its nine bits is 1. With `odd_sel` = 0, a lane passes when that XOR is 0.
- R3: When `port_en` = 1, `err_n` is 0 exactly when at least one checked lane fails. This holds in the same cycle as the inputs, with no register in the path.
- R4: When `port_en` = 0, `err_n` is 1 whatever the bus and select inputs are.
- R5: In the wide variant (`NARROW` = 0), all four lanes are checked, and `size_sel` and `lane_sel` have no effect on `err_n`.
- R6: In the narrow variant, `size_sel` = 2'b00 (long word) and `size_sel` = 2'b11 (full-width register access) both check all four lanes.
- R7: In the narrow variant, `size_sel` = 2'b01 (word) checks lanes 0 and 1 when `lane_sel[1]` = 0, and lanes 2 and 3 when `lane_sel[1]` = 1. `lane_sel[0]` has no effect in this mode.
- R8: In the narrow variant, `size_sel` = 2'b10 (byte) checks only the lane numbered by `lane_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_in | input | 36 | Four 9-bit lanes, parity in the top bit of each lane |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| size_sel | input | 2 | Bus size: 00 long, 01 word, 10 byte, 11 full-width register |
| lane_sel | input | 2 | Active lane (byte mode) or lane pair in bit 1 (word mode) |
| port_en | input | 1 | 1 when the port is driving data into the block |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bound checker tests the following on every input change:
- A disabled port never shows an error.
- A low flag always points at a lane that really fails.
- A fully clean bus always leaves the flag high.
- In byte mode, a low flag means the selected lane itself fails.
- In the wide variant, any failing lane on an enabled port drives the flag low.

Only the bench's directed scenarios can show that masking is exact. A bad lane outside the current word pair or byte must leave the flag high. The bench also shows that `lane_sel[0]` is ignored in word mode and that the parity sense flips with the select.

// File: rtl/lane_parity_check.sv
module lane_parity_check #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter bit NARROW = 1'b1,
  localparam int BUS_W = LANES * LANE_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [BUS_W-1:0] bus_in,
  input  logic             odd_sel,
  input  logic [1:0]       size_sel,
  input  logic [SEL_W-1:0] lane_sel,
  input  logic             port_en,
  output logic             err_n
);

  logic [LANES-1:0] lane_fail;
  logic [LANES-1:0] chk_mask;

  for (genvar g = 0; g < LANES; g++) begin : g_tree
    assign lane_fail[g] = (^bus_in[g*LANE_W +: LANE_W]) ^ odd_sel;
  end

  if (NARROW) begin : g_narrow
    always_comb begin
      for (int i = 0; i < LANES; i++) begin
        unique case (size_sel)
          2'b01:   chk_mask[i] = (lane_sel >> 1) == SEL_W'(i >> 1);
          2'b10:   chk_mask[i] = lane_sel == SEL_W'(i);
          default: chk_mask[i] = 1'b1;
        endcase
      end
    end
  end else begin : g_wide
    assign chk_mask = '1;
  end

  assign err_n = !(port_en && |(lane_fail & chk_mask));

endmodule

module lane_parity_check_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter bit NARROW = 1'b1,
  localparam int BUS_W = LANES * LANE_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input logic [BUS_W-1:0] bus_in,
  input logic             odd_sel,
  input logic [1:0]       size_sel,
  input logic [SEL_W-1:0] lane_sel,
  input logic             port_en,
  input logic             err_n
);
  logic [LANES-1:0] bad;
  always_comb
    for (int i = 0; i < LANES; i++)
      bad[i] = (^bus_in[i*LANE_W +: LANE_W]) != odd_sel;

  always_comb begin
    // R4
    off_quiet_chk: assert (port_en || err_n);
    // R3
    low_has_cause_chk: assert (err_n || (|bad));
    // R2
    clean_high_chk: assert ((|bad) || err_n);
    // R8
    if (NARROW && size_sel == 2'b10 && !err_n)
      byte_lane_chk: assert (bad[lane_sel]);
    // R5
    if (!NARROW && port_en && (|bad))
      wide_all_chk: assert (!err_n);
  end
endmodule

bind lane_parity_check lane_parity_check_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .NARROW(NARROW)
) chk_i (
  .bus_in(bus_in), .odd_sel(odd_sel), .size_sel(size_sel),
  .lane_sel(lane_sel), .port_en(port_en), .err_n(err_n)
);

// File: tb/lane_parity_check_tb.sv
module lane_parity_check_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [35:0] bus_in;
  logic        odd_sel, port_en;
  logic [1:0]  size_sel, lane_sel;
  logic        err_n, err_w_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  lane_parity_check #(.NARROW(1'b1)) dut_i (
    .bus_in(bus_in), .odd_sel(odd_sel), .size_sel(size_sel),
    .lane_sel(lane_sel), .port_en(port_en), .err_n(err_n));

  lane_parity_check #(.NARROW(1'b0)) dutw_i (
    .bus_in(bus_in), .odd_sel(odd_sel), .size_sel(size_sel),
    .lane_sel(lane_sel), .port_en(port_en), .err_n(err_w_n));

  // R1/R2: lane k at bits 9k..9k+8, parity bit at 9k+8; bad lanes get a flipped parity bit
  function automatic logic [35:0] mk(input logic [3:0] bad, input logic odd,
                                     input logic [31:0] d);
    logic [35:0] r;
    for (int k = 0; k < 4; k++) begin
      r[9*k +: 8] = d[8*k +: 8];
      r[9*k+8]    = (^d[8*k +: 8]) ^ odd ^ bad[k];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] bad, input logic odd, input logic [31:0] d,
                       input logic [1:0] sz, input logic [1:0] ln, input logic en);
    @(posedge clk);
    bus_in = mk(bad, odd, d); odd_sel = odd; size_sel = sz; lane_sel = ln; port_en = en;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R4 reset narrow", err_n, 1'b1);
    chk("R4 reset wide", err_w_n, 1'b1);
  endtask

  task automatic t_sense;
    apply(4'b0000, 1'b1, 32'hA5C3_0F71, 2'b00, 2'b00, 1'b1);
    chk("R2 odd clean", err_n, 1'b1);
    apply(4'b0000, 1'b0, 32'hA5C3_0F71, 2'b00, 2'b00, 1'b1);
    chk("R2 even clean", err_n, 1'b1);
    apply(4'b0000, 1'b1, 32'h1234_5678, 2'b00, 2'b00, 1'b1);
    odd_sel = 1'b0; #0; @(negedge clk);
    chk("R2 odd data under even sense", err_n, 1'b0);
    for (int k = 0; k < 4; k++) begin
      apply(4'(1 << k), 1'b0, 32'hFFFF_0000, 2'b00, 2'b00, 1'b1);
      chk($sformatf("R1 R3 lane %0d bad", k), err_n, 1'b0);
    end
    apply(4'b0000, 1'b1, 32'h0, 2'b00, 2'b00, 1'b1);
    bus_in[8] = ~bus_in[8]; @(negedge clk);
    chk("R1 parity bit position lane0", err_n, 1'b0);
  endtask

  task automatic t_disable;
    apply(4'b1111, 1'b1, 32'hDEAD_BEEF, 2'b00, 2'b00, 1'b0);
    chk("R4 disabled narrow", err_n, 1'b1);
    chk("R4 disabled wide", err_w_n, 1'b1);
    port_en = 1'b1; @(negedge clk);
    chk("R3 enabled again", err_n, 1'b0);
  endtask

  task automatic t_long;
    apply(4'b1000, 1'b1, 32'h0102_0304, 2'b00, 2'b01, 1'b1);
    chk("R6 long lane3 bad", err_n, 1'b0);
    apply(4'b0001, 1'b0, 32'h0102_0304, 2'b11, 2'b10, 1'b1);
    chk("R6 full-width lane0 bad", err_n, 1'b0);
  endtask

  task automatic t_word;
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 4; b++)
        for (int s0 = 0; s0 < 2; s0++) begin
          apply(4'(1 << b), 1'b1, 32'h55AA_33CC, 2'b01, {p[0], s0[0]}, 1'b1);
          chk($sformatf("R7 pair %0d bad lane %0d sel0 %0d", p, b, s0),
              err_n, (b / 2 == p) ? 1'b0 : 1'b1);
        end
  endtask

  task automatic t_byte;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        apply(4'(1 << b), 1'b0, 32'h8001_7FFE, 2'b10, 2'(a), 1'b1);
        chk($sformatf("R8 active %0d bad %0d", a, b), err_n, (a == b) ? 1'b0 : 1'b1);
      end
    apply(4'b1110, 1'b1, 32'h0, 2'b10, 2'b00, 1'b1);
    chk("R8 only lane0 counted", err_n, 1'b1);
  endtask

  task automatic t_wide;
    for (int b = 0; b < 4; b++) begin
      apply(4'(1 << b), 1'b1, 32'hC0FF_EE11, 2'b10, 2'(b ^ 1), 1'b1);
      chk($sformatf("R5 wide byte mode bad lane %0d", b), err_w_n, 1'b0);
      size_sel = 2'b01; lane_sel = 2'(~b); @(negedge clk);
      chk($sformatf("R5 wide word mode bad lane %0d", b), err_w_n, 1'b0);
    end
    apply(4'b0000, 1'b1, 32'hC0FF_EE11, 2'b10, 2'b11, 1'b1);
    chk("R5 wide clean", err_w_n, 1'b1);
  endtask

  initial begin
    bus_in = '0; odd_sel = 1'b1; size_sel = 2'b00; lane_sel = 2'b00; port_en = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sense();
    t_disable();
    t_long();
    t_word();
    t_byte();
    t_wide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule